// File: doc/BRIEF.md
# Memory Readiness and Clock-Loss Monitor

This block watches a synchronous memory's start-up and decides when two slow internal mechanisms may be treated as settled. The first is the output-driver impedance calibration. It may only adjust itself in cycles where the data outputs are idle, and it is considered optimal once enough idle cycles have gone by. The second is the clock delay-locked loop. It needs a fixed number of clock cycles to settle after power-up, and again after any period in which the main clock stopped.

A free-running reference clock watches the main clock. If no main-clock rising edge arrives for a set number of reference cycles, the block drives a DLL reset. That reset also clears the DLL readiness count at once, even while the main clock is stopped. When main-clock edges come back, the reset is released and the settle count starts again from zero. The block also picks the clock mode. At the first main-clock edge after reset release it samples the two output-clock pins, and it keeps that result until the next reset. The active-low reset stands for power-up.

Top module: `mem_ready_mon`

## Requirements
- R1: The impedance cycle count rises by one on each main-clock edge at which `read_i` is 0 and stays unchanged on each edge at which `read_i` is 1; `imp_ready_o` is 1 exactly when 1024 such non-read edges have been counted since reset.
- R2: The impedance count saturates at 1024, so `imp_ready_o` stays 1 through any later pattern of read and non-read cycles until reset.
- R3: `imp_upd_o` is never 1 in a cycle with `read_i` = 1; it is 1 in the cycle of every fourth non-read cycle after reset (the 4th, 8th, 12th, ...), counted over non-read cycles only.
- R4: After reset release, `dll_ready_o` stays 0 for at least the first 1024 main-clock edges and is 1 no later than edge 1032 if the main clock keeps running.
- R5: If no main-clock rising edge is seen for 16 reference-clock cycles, `dll_rst_o` goes to 1 and `dll_ready_o` goes to 0 without needing any main-clock edge.
- R6: Once main-clock edges resume, `dll_rst_o` returns to 0 within a few main-clock cycles; `dll_ready_o` stays 0 for at least the first 1024 resumed edges and is 1 by edge 1040.
- R7: `single_clk_o` takes the value (`oclk_p_i` AND `oclk_n_i`) sampled at the first main-clock edge after reset release, and is 0 before that edge.
- R8: Changes on `oclk_p_i` or `oclk_n_i` after that first edge have no effect on `single_clk_o` until the next reset.
- R9: While `rst_ni` is low, `imp_ready_o`, `imp_upd_o`, `dll_ready_o`, `dll_rst_o` and `single_clk_o` are all 0.
- R10: A main-clock stop and the DLL reset it causes do not change the impedance count or `imp_ready_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main clock, may be stopped |
| ref_clk_i | input | 1 | Free-running reference clock, faster than clk_i, used for loss detection |
| rst_ni | input | 1 | Active-low asynchronous reset (power-up) |
| read_i | input | 1 | 1 in cycles where the data outputs are driven |
| oclk_p_i | input | 1 | Output-clock pin, sampled for mode selection |
| oclk_n_i | input | 1 | Complementary output-clock pin, sampled for mode selection |
| imp_ready_o | output | 1 | Impedance calibration settled |
| imp_upd_o | output | 1 | Impedance update strobe, idle cycles only |
| dll_ready_o | output | 1 | DLL settle count complete |
| dll_rst_o | output | 1 | DLL reset forced by main-clock loss |
| single_clk_o | output | 1 | Single clock mode latched at power-up |

## Verification
A main-clock stop that causes a DLL reset can land while the impedance count is saturated and reads are mixed into the traffic. The bench stops the main clock right after a mixed read/idle stretch with `imp_ready_o` already high. During the stop and for the whole restart window, it checks that the impedance outputs still follow the cycle model while `dll_ready_o` falls and then rebuilds its count. The strobe timing also shares cycles with the read pattern, so every cycle's `imp_upd_o` is compared against a model that counts only idle cycles.

// File: rtl/rdy_pkg.sv
package rdy_pkg;
  localparam int unsigned CAL_CYCLES_DEF   = 1024;
  localparam int unsigned DLL_CYCLES_DEF   = 1024;
  localparam int unsigned UPD_INTERVAL_DEF = 4;
  localparam int unsigned LOSS_CYCLES_DEF  = 16;

  function automatic int unsigned cnt_w(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/rdy_sat_counter.sv
module rdy_sat_counter #(
  parameter int unsigned MAX = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic full_o
);
  localparam int unsigned W = rdy_pkg::cnt_w(MAX);
  localparam logic [W-1:0] MAX_V = W'(MAX);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (en_i && (cnt_q != MAX_V)) cnt_q <= cnt_q + 1'b1;
  end

  assign full_o = (cnt_q == MAX_V);

  p_no_overflow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= MAX_V);
  p_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cnt_q));
  p_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !full_o) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/imp_calib.sv
module imp_calib #(
  parameter int unsigned CAL_CYCLES   = 1024,
  parameter int unsigned UPD_INTERVAL = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic read_i,
  output logic ready_o,
  output logic upd_o
);
  logic idle;
  assign idle = !read_i;

  rdy_sat_counter #(.MAX(CAL_CYCLES)) u_cal_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (idle),
    .full_o (ready_o)
  );

  generate
    if (UPD_INTERVAL > 1) begin : g_interval
      localparam int unsigned IW = $clog2(UPD_INTERVAL);
      localparam logic [IW-1:0] LAST = IW'(UPD_INTERVAL - 1);
      logic [IW-1:0] ic_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   ic_q <= '0;
        else if (idle) ic_q <= (ic_q == LAST) ? '0 : ic_q + 1'b1;
      end

      assign upd_o = rst_ni && idle && (ic_q == LAST);

      p_upd_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        upd_o |=> (ic_q == '0));
      p_upd_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        upd_o |=> !upd_o);
      p_read_freeze_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        read_i |=> $stable(ic_q));
    end else begin : g_every
      assign upd_o = rst_ni && idle;
    end
  endgenerate
endmodule

// File: rtl/clk_loss_mon.sv
module clk_loss_mon #(
  parameter int unsigned LOSS_CYCLES = 16
) (
  input  logic clk_i,
  input  logic ref_clk_i,
  input  logic rst_ni,
  output logic lost_o
);
  localparam int unsigned LW = rdy_pkg::cnt_w(LOSS_CYCLES);
  localparam logic [LW-1:0] LIMIT = LW'(LOSS_CYCLES);

  logic         tgl_q;
  logic [2:0]   sync_q;
  logic         seen;
  logic [LW-1:0] cnt_q, cnt_d;
  logic         lost_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tgl_q <= 1'b0;
    else         tgl_q <= ~tgl_q;
  end

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[1:0], tgl_q};
  end

  assign seen = sync_q[2] ^ sync_q[1];

  always_comb begin
    if (seen)                cnt_d = '0;
    else if (cnt_q != LIMIT) cnt_d = cnt_q + 1'b1;
    else                     cnt_d = cnt_q;
  end

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      lost_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      lost_q <= (cnt_d == LIMIT);
    end
  end

  assign lost_o = lost_q;

  p_loss_r5: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    (!seen && (cnt_q == LIMIT - 1'b1)) |=> lost_q);
  p_release_r6: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    seen |=> !lost_q);
endmodule

// File: rtl/mem_ready_mon.sv
module mem_ready_mon #(
  parameter int unsigned CAL_CYCLES      = rdy_pkg::CAL_CYCLES_DEF,
  parameter int unsigned DLL_CYCLES      = rdy_pkg::DLL_CYCLES_DEF,
  parameter int unsigned UPD_INTERVAL    = rdy_pkg::UPD_INTERVAL_DEF,
  parameter int unsigned LOSS_REF_CYCLES = rdy_pkg::LOSS_CYCLES_DEF
) (
  input  logic clk_i,
  input  logic ref_clk_i,
  input  logic rst_ni,
  input  logic read_i,
  input  logic oclk_p_i,
  input  logic oclk_n_i,
  output logic imp_ready_o,
  output logic imp_upd_o,
  output logic dll_ready_o,
  output logic dll_rst_o,
  output logic single_clk_o
);
  imp_calib #(
    .CAL_CYCLES   (CAL_CYCLES),
    .UPD_INTERVAL (UPD_INTERVAL)
  ) u_imp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .read_i  (read_i),
    .ready_o (imp_ready_o),
    .upd_o   (imp_upd_o)
  );

  clk_loss_mon #(.LOSS_CYCLES(LOSS_REF_CYCLES)) u_loss (
    .clk_i     (clk_i),
    .ref_clk_i (ref_clk_i),
    .rst_ni    (rst_ni),
    .lost_o    (dll_rst_o)
  );

  // clock loss clears the DLL count asynchronously; release is synchronised
  logic       dll_arst_n;
  logic [1:0] dll_sync_q;
  assign dll_arst_n = rst_ni & ~dll_rst_o;

  always_ff @(posedge clk_i or negedge dll_arst_n) begin
    if (!dll_arst_n) dll_sync_q <= '0;
    else             dll_sync_q <= {dll_sync_q[0], 1'b1};
  end

  rdy_sat_counter #(.MAX(DLL_CYCLES)) u_dll_cnt (
    .clk_i  (clk_i),
    .rst_ni (dll_sync_q[1]),
    .en_i   (1'b1),
    .full_o (dll_ready_o)
  );

  // clock mode, frozen after the first edge out of reset
  logic init_q, single_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q   <= 1'b0;
      single_q <= 1'b0;
    end else if (!init_q) begin
      init_q   <= 1'b1;
      single_q <= oclk_p_i & oclk_n_i;
    end
  end
  assign single_clk_o = single_q;

  p_capture_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_q |=> (single_q == ($past(oclk_p_i) && $past(oclk_n_i))));
  p_frozen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_q && $past(init_q)) |-> $stable(single_q));
  p_dll_clear_r5: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    dll_rst_o |-> !dll_ready_o);
  p_dll_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dll_sync_q[1] |=> !dll_ready_o);
endmodule

// File: tb/mem_ready_mon_bench.sv
module mem_ready_mon_bench;
  logic clk = 1'b0, ref_clk = 1'b0, clk_en = 1'b1;
  logic rst_ni = 1'b0, read_i = 1'b0, oclk_p = 1'b1, oclk_n = 1'b1;
  logic imp_ready, imp_upd, dll_ready, dll_rst, single_clk;

  int checks = 0, failures = 0;

  // model state
  int  m_cnt = 0, m_ic = 0, since = 0;
  bit  m_cap = 0, m_single = 0, prev_read = 0, dll_chk = 0;
  int  dll_hi = 1032;

  // 125 MHz main clock (8 ns), 3 ns reference clock
  always #4 clk = clk_en ? ~clk : 1'b0;
  always begin
    #1 ref_clk = 1'b1;
    #2 ref_clk = 1'b0;
  end

  mem_ready_mon u_mem_ready_mon (
    .clk_i (clk), .ref_clk_i (ref_clk), .rst_ni (rst_ni), .read_i (read_i),
    .oclk_p_i (oclk_p), .oclk_n_i (oclk_n),
    .imp_ready_o (imp_ready), .imp_upd_o (imp_upd), .dll_ready_o (dll_ready),
    .dll_rst_o (dll_rst), .single_clk_o (single_clk)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic cmp_bit(input logic act, input bit exp, input string req);
    chk(act === exp, req, int'(act), int'(exp));
  endtask

  // one main-clock cycle: model the posedge just passed, drive, compare
  task automatic cyc(input bit r);
    @(negedge clk);
    if (!rst_ni) begin
      m_cnt = 0; m_ic = 0; m_cap = 0; m_single = 0;
    end else begin
      if (!prev_read) begin
        if (m_cnt < 1024) m_cnt++;
        m_ic = (m_ic + 1) % 4;
      end
      if (!m_cap) begin
        m_cap = 1; m_single = oclk_p & oclk_n;
      end
      since++;
    end
    prev_read = r;
    read_i = r;
    #3;
    if (!rst_ni) begin
      cmp_bit(imp_ready, 0, "R9 imp_ready");
      cmp_bit(imp_upd, 0, "R9 imp_upd");
      cmp_bit(dll_ready, 0, "R9 dll_ready");
      cmp_bit(dll_rst, 0, "R9 dll_rst");
      cmp_bit(single_clk, 0, "R9 single_clk");
    end else begin
      cmp_bit(imp_ready, m_cnt == 1024, "R1 R2 imp_ready");
      cmp_bit(imp_upd, !r && m_ic == 3, "R3 imp_upd");
      cmp_bit(single_clk, m_single, "R7 R8 single_clk");
      if (dll_chk) begin
        if (since <= 1024) cmp_bit(dll_ready, 0, "R4 R6 dll_ready early");
        if (since >= dll_hi) cmp_bit(dll_ready, 1, "R4 R6 dll_ready late");
        if (since >= 8) cmp_bit(dll_rst, 0, "R6 dll_rst released");
      end
    end
  endtask

  task automatic do_reset(input bit p, input bit n);
    rst_ni = 1'b0;
    oclk_p = p; oclk_n = n;
    for (int i = 0; i < 5; i++) cyc(1'b0);
    rst_ni = 1'b1;
    since = 0; dll_chk = 1; dll_hi = 1032;
  endtask

  initial begin
    // power-up with both output-clock pins high
    do_reset(1'b1, 1'b1);
    for (int i = 0; i < 1700; i++) begin
      if (i == 10) begin oclk_p = 1'b0; oclk_n = 1'b0; end  // R8
      if (i == 20) oclk_p = 1'b1;
      cyc(i % 3 == 0);
    end
    // all reads: ready holds, no strobe (R2, R3)
    for (int i = 0; i < 200; i++) cyc(1'b1);
    // bursty pattern
    for (int i = 0; i < 300; i++) cyc((i % 7) < 3);

    // stop the main clock (R5, R10)
    clk_en = 1'b0; dll_chk = 0;
    #300;
    cmp_bit(dll_rst, 1, "R5 dll_rst during stop");
    cmp_bit(dll_ready, 0, "R5 dll_ready during stop");
    cmp_bit(imp_ready, 1, "R10 imp_ready during stop");
    cmp_bit(single_clk, 1, "R8 single_clk during stop");
    since = 0; dll_chk = 1; dll_hi = 1040;
    clk_en = 1'b1;
    for (int i = 0; i < 1100; i++) cyc(i % 5 == 0);

    // second power-up with pins not both high (R7)
    do_reset(1'b1, 1'b0);
    for (int i = 0; i < 1100; i++) begin
      if (i == 3) oclk_n = 1'b1;  // R8: late change ignored
      cyc(i % 2 == 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule